// File: doc/BRIEF.md
# Dual-Bank Program Memory Address Decoder

This block sits between an instruction fetch unit and the program memories. Each fetch address is routed to one of three targets: a primary on-chip flash bank that starts at address zero, a 4 KB secondary on-chip bank, or the external program bus. The primary bank is 16 KB or 32 KB, set by a parameter.

The secondary bank normally answers in the topmost 4 KB window of the 64 KB space. A visibility input can hide it from that window, and those fetches then go to the external bus. A two-bit remap field can also overlay the first 1, 2 or 4 KB of the secondary bank on the bottom of the address space, in front of the primary bank. While that overlay is active, the secondary bank is still reachable at the top window. A forced-external input sends every fetch to the external bus.

The remap field is held in the block. It takes its value from a configuration input during reset, and software can rewrite it at any time. Fetch requests enter through a valid/ready handshake. Each decoded result leaves through a single registered output stage that also uses valid/ready. A request is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output stage is empty or its result is taken in that same cycle. A result is held unchanged for as long as `out_ready` stays low. Each accepted fetch is decoded with the remap value that is in force on the edge that accepts it.

Top module: `pmem_bank_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1. The remap field takes the value of `cfg_remap_init` during reset.
- R2: With no forced-external access and no remap hit, an address below the primary bank size gives `out_bank` = 00 (primary), and `out_offset` equals the address.
- R3: With `sec_visible` = 1, an address in F000h–FFFFh gives `out_bank` = 01 (secondary), and `out_offset` = address − F000h. This holds whatever the remap value.
- R4: With `sec_visible` = 0, an address in F000h–FFFFh gives `out_bank` = 10 (external).
- R5: Any address that no internal bank covers gives `out_bank` = 10, and `out_offset` equals the address. `out_ext_en` is 1 exactly when a valid result has `out_bank` = 10.
- R6: With `ext_force` = 1, every address gives `out_bank` = 10.
- R7: The remap encoding is 00 = none, 01 = 1 KB, 10 = 2 KB, 11 = 4 KB. An address below the selected size gives `out_bank` = 01, and `out_offset` equals the address. This takes priority over the primary bank.
- R8: A remap write takes effect for fetches accepted after the write edge. A fetch accepted on the same edge as the write uses the old value. A result already held in the output stage does not change.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, and `out_bank` and `out_offset` stay stable.
- R10: A result appears on the outputs one clock edge after its request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fetch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_remap_init | input | 2 | Remap value loaded during reset |
| cfg_remap_wr | input | 1 | Software write strobe for the remap field |
| cfg_remap_wdata | input | 2 | Software write data for the remap field |
| in_valid | input | 1 | Fetch request valid |
| in_ready | output | 1 | Decoder can accept a request |
| in_addr | input | 16 | Fetch address |
| ext_force | input | 1 | Forced external access level for this request |
| sec_visible | input | 1 | Secondary bank visible at the top window |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_bank | output | 2 | 00 primary, 01 secondary, 10 external |
| out_offset | output | 16 | Offset within the selected bank (full address when external) |
| out_ext_en | output | 1 | External fetch strobe enable |

## Verification
The hardest case to reach is a remap write that lands while a decoded result is held by back-pressure, or on the same edge that accepts a fetch. The bench creates both cases on purpose. It first holds `out_ready` low and writes the remap field while a primary-bank result is waiting in the output stage. It then drives the write strobe and a request on the same cycle. In both cases the bench checks that only later fetches see the new overlay. Around these checks, a sweep covers every remap value, both visibility levels and both forced-external levels, using addresses on each 256-byte boundary and its last byte. This catches every bank edge.

// File: rtl/pmdec_pkg.sv
package pmdec_pkg;
  typedef enum logic [1:0] {
    BANK_PRI = 2'b00,
    BANK_SEC = 2'b01,
    BANK_EXT = 2'b10
  } bank_e;
endpackage

// File: rtl/pmdec_remap_reg.sv
module pmdec_remap_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] init_val,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic [1:0] remap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     remap_q <= init_val;
    else if (wr_en) remap_q <= wr_data;
  end
endmodule

// File: rtl/pmdec_map.sv
module pmdec_map
  import pmdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PRI_KB = 16,
  parameter int SEC_KB = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_force,
  input  logic              sec_visible,
  input  logic [1:0]        remap,
  output bank_e             bank,
  output logic [ADDR_W-1:0] offset
);
  localparam logic [ADDR_W:0]   PRI_LIM  = (ADDR_W+1)'(PRI_KB * 1024);
  localparam logic [ADDR_W:0]   SEC_LIM  = (ADDR_W+1)'(SEC_KB * 1024);
  localparam logic [ADDR_W-1:0] SEC_BASE = ADDR_W'((1 << ADDR_W) - SEC_KB * 1024);

  logic [ADDR_W:0] remap_lim;
  logic [ADDR_W:0] addr_x;

  assign addr_x = {1'b0, addr};

  always_comb begin
    unique case (remap)
      2'b01:   remap_lim = SEC_LIM >> 2;
      2'b10:   remap_lim = SEC_LIM >> 1;
      2'b11:   remap_lim = SEC_LIM;
      default: remap_lim = '0;
    endcase
  end

  always_comb begin
    bank   = BANK_EXT;
    offset = addr;
    if (ext_force) begin
      bank = BANK_EXT;
    end else if (addr_x < remap_lim) begin
      bank = BANK_SEC;
    end else if (addr_x < PRI_LIM) begin
      bank = BANK_PRI;
    end else if (sec_visible && addr >= SEC_BASE) begin
      bank   = BANK_SEC;
      offset = addr - SEC_BASE;
    end
  end
endmodule

// File: rtl/pmdec_slice.sv
module pmdec_slice #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/pmem_bank_decoder.sv
module pmem_bank_decoder
  import pmdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PRI_KB = 16,
  parameter int SEC_KB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_remap_init,
  input  logic              cfg_remap_wr,
  input  logic [1:0]        cfg_remap_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              ext_force,
  input  logic              sec_visible,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_bank,
  output logic [ADDR_W-1:0] out_offset,
  output logic              out_ext_en
);
  localparam int RES_W = ADDR_W + 2;

  logic [1:0]        remap_q;
  bank_e             dec_bank;
  logic [ADDR_W-1:0] dec_off;
  logic [RES_W-1:0]  res_q;

  pmdec_remap_reg u_remap (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_val (cfg_remap_init),
    .wr_en    (cfg_remap_wr),
    .wr_data  (cfg_remap_wdata),
    .remap_q  (remap_q)
  );

  pmdec_map #(.ADDR_W(ADDR_W), .PRI_KB(PRI_KB), .SEC_KB(SEC_KB)) u_map (
    .addr        (in_addr),
    .ext_force   (ext_force),
    .sec_visible (sec_visible),
    .remap       (remap_q),
    .bank        (dec_bank),
    .offset      (dec_off)
  );

  pmdec_slice #(.W(RES_W)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({dec_bank, dec_off}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q)
  );

  assign out_bank   = res_q[RES_W-1 -: 2];
  assign out_offset = res_q[ADDR_W-1:0];
  assign out_ext_en = out_valid && (res_q[RES_W-1 -: 2] == BANK_EXT);
endmodule

// File: rtl/pmdec_checker.sv
module pmdec_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              ext_force,
  input logic              sec_visible,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_bank,
  input logic [ADDR_W-1:0] out_offset,
  input logic              out_ext_en
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bank) && $stable(out_offset));

  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r6_forced: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ext_force |=> out_bank == 2'b10 && out_ext_en);

  a_r3_top_window: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ext_force && sec_visible && (in_addr[ADDR_W-1 -: 4] == 4'hF)
    |=> out_bank == 2'b01 && out_offset == {4'h0, $past(in_addr[ADDR_W-5:0])});

  a_r4_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ext_force && !sec_visible && (in_addr[ADDR_W-1 -: 4] == 4'hF)
    |=> out_bank == 2'b10);

  a_r5_ext_en: assert property (@(posedge clk) disable iff (!rst_n)
    out_ext_en |-> out_valid && out_bank == 2'b10);
endmodule

bind pmem_bank_decoder pmdec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_addr     (in_addr),
  .ext_force   (ext_force),
  .sec_visible (sec_visible),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_bank    (out_bank),
  .out_offset  (out_offset),
  .out_ext_en  (out_ext_en)
);

// File: tb/pmem_bank_decoder_tb_top.sv
module pmem_bank_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  cfg_remap_init = 2'b10;
  logic        cfg_remap_wr = 0;
  logic [1:0]  cfg_remap_wdata = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_addr = 0;
  logic        ext_force = 0;
  logic        sec_visible = 1;
  logic        out_valid;
  logic        out_ready = 1;
  logic [1:0]  out_bank;
  logic [15:0] out_offset;
  logic        out_ext_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] cur_remap = 2'b10;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmem_bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_remap_init(cfg_remap_init), .cfg_remap_wr(cfg_remap_wr),
    .cfg_remap_wdata(cfg_remap_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .ext_force(ext_force), .sec_visible(sec_visible),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_bank(out_bank), .out_offset(out_offset), .out_ext_en(out_ext_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int model_bank(int a, bit ef, bit vis, logic [1:0] rm);
    int lim = (rm == 2'b01) ? 1024 : (rm == 2'b10) ? 2048 : (rm == 2'b11) ? 4096 : 0;
    if (ef) return 2;
    if (a < lim) return 1;
    if (a < 16384) return 0;
    if (vis && a >= 'hF000) return 1;
    return 2;
  endfunction

  function automatic int model_off(int a, bit ef, bit vis, logic [1:0] rm);
    if (model_bank(a, ef, vis, rm) == 1 && a >= 'hF000) return a - 'hF000;
    return a;
  endfunction

  function automatic string req_of(int a, bit ef, bit vis, logic [1:0] rm);
    int b = model_bank(a, ef, vis, rm);
    if (ef) return "R6";
    if (b == 1 && a < 4096) return "R7";
    if (b == 1) return "R3";
    if (a >= 'hF000) return "R4";
    if (b == 0) return "R2";
    return "R5";
  endfunction

  task automatic fetch(input int a, input bit ef, input bit vis);
    int eb, eo;
    string rq;
    @(negedge clk);
    in_addr = a[15:0]; ext_force = ef; sec_visible = vis;
    in_valid = 1; out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    eb = model_bank(a, ef, vis, cur_remap);
    eo = model_off(a, ef, vis, cur_remap);
    rq = req_of(a, ef, vis, cur_remap);
    chk(out_valid === 1'b1, "R10", int'(out_valid), 1);
    chk(out_bank === eb[1:0], rq, int'(out_bank), eb);
    chk(out_offset === eo[15:0], rq, int'(out_offset), eo);
    chk(out_ext_en === (eb == 2), "R5", int'(out_ext_en), int'(eb == 2));
  endtask

  task automatic wr_remap(input logic [1:0] v);
    @(negedge clk);
    cfg_remap_wr = 1; cfg_remap_wdata = v;
    @(negedge clk);
    cfg_remap_wr = 0;
    cur_remap = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1", int'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1", int'(in_ready), 1);

    // R1: reset value 10 selects a 2 KB overlay
    fetch('h0500, 0, 1);
    fetch('h0900, 0, 1);

    // sweep: R2 R3 R4 R5 R6 R7
    for (int rm = 0; rm < 4; rm++) begin
      wr_remap(rm[1:0]);
      for (int ef = 0; ef < 2; ef++)
        for (int vis = 0; vis < 2; vis++)
          for (int k = 0; k < 256; k++)
            for (int e = 0; e < 2; e++)
              fetch(k * 256 + e * 255, ef[0], vis[0]);
    end

    // R8 + R9: remap write while a result is held under back-pressure
    wr_remap(2'b00);
    @(negedge clk);
    in_addr = 16'h0100; ext_force = 0; sec_visible = 1; in_valid = 1; out_ready = 0;
    @(posedge clk);
    @(negedge clk);
    in_addr = 16'h0200;
    cfg_remap_wr = 1; cfg_remap_wdata = 2'b11;
    chk(in_ready === 1'b0, "R9", int'(in_ready), 0);
    chk(out_bank === 2'b00, "R9", int'(out_bank), 0);
    @(negedge clk);
    cfg_remap_wr = 0; cur_remap = 2'b11;
    chk(out_bank === 2'b00, "R8", int'(out_bank), 0);
    chk(out_offset === 16'h0100, "R8", int'(out_offset), 'h100);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_bank === 2'b01, "R8", int'(out_bank), 1);
    chk(out_offset === 16'h0200, "R8", int'(out_offset), 'h200);

    // R8: write on the same edge as acceptance uses the old value
    wr_remap(2'b00);
    @(negedge clk);
    in_addr = 16'h0100; in_valid = 1; out_ready = 1;
    cfg_remap_wr = 1; cfg_remap_wdata = 2'b01;
    @(negedge clk);
    cfg_remap_wr = 0; in_valid = 0; cur_remap = 2'b01;
    chk(out_bank === 2'b00, "R8", int'(out_bank), 0);
    fetch('h0100, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule